// File: doc/BRIEF.md
# Balanced Vector Sparsity Pruner

This block takes the weights of one matrix row as a stream, one signed element per accepted cycle. It cuts the row into consecutive groups of `L` elements. In every group it keeps exactly `K` elements, the ones with the largest absolute value. Each group then leaves the block as one compact packet. The packet holds the `K` kept values, the position of each kept value inside its group, and the number of zero elements the group held before pruning. Every group comes out with the same count of kept elements, so a downstream multiply array can handle each group in a fixed number of steps. It uses the local positions to pick the matching operand rows.

A row can end partway through a group; the producer marks its final element with `in_last`. In that case the block fills the rest of the group with zero elements. It stops taking input for one cycle per filled slot, then prunes the group as usual. Both the input side and the packet side use a valid/ready handshake, and a stalled packet side holds back the input.

Top module: `vw_sparse_pruner`

## Requirements
- R1: Group g of a row holds row elements g·L through g·L+L−1, in arrival order. Exactly one packet leaves for each group, and packets leave in group order.
- R2: If `in_last` arrives while a group is incomplete, the missing positions count as zero-valued elements. While the block fills them, `in_ready` stays low. The next accepted element starts a new group at position 0.
- R3: Each packet carries exactly K kept values. These are the K elements of largest absolute value, with the signed inputs read as two's complement, so −128 ranks above 127 at 8 bits.
- R4: Among elements of equal absolute value, the one at the lower position wins. If a group has fewer than K nonzero elements, the remaining slots are filled by zero elements taken from the lowest positions not yet kept.
- R5: Kept elements appear in strictly ascending position order. Slot s sits at bits [s·DW +: DW] of `out_vals` and its position at bits [s·OW +: OW] of `out_offs`, where OW = $clog2(L).
- R6: `out_zeros` equals the number of zero elements in the group, counting filled positions, and lies in 0..L.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and every packet output holds its value on the next cycle.
- R8: While reset is applied and right after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Block accepts an element this cycle |
| in_data | input | DW | Signed weight element |
| in_last | input | 1 | Element is the final one of its row |
| out_valid | output | 1 | Packet present |
| out_ready | input | 1 | Consumer takes the packet this cycle |
| out_vals | output | K·DW | Kept values, slot 0 in the low bits |
| out_offs | output | K·OW | Position of each kept value within its group |
| out_zeros | output | ZW | Zero count of the group, ZW = $clog2(L+1) |

## Verification
The assertions check four things on every cycle. A stalled packet must stay fixed. A presented packet must have strictly rising positions. Its count of nonzero kept values must equal the smaller of K and the group's nonzero count. A finished group must keep its contents while it waits to be handed on. The bench's scenarios cover what these rules cannot see: whether the right elements were chosen, tie breaking and zero filling, the alignment and zero filling of short rows across every row length up to 2L+1, and that no packet is lost or duplicated under a shifting stall pattern.

// File: rtl/vw_prune_pkg.sv
package vw_prune_pkg;
    typedef enum logic [1:0] {
        MODE_FILL = 2'd0,
        MODE_PAD  = 2'd1,
        MODE_HOLD = 2'd2
    } vw_mode_e;
endpackage

// File: rtl/vw_group_collect.sv
module vw_group_collect
    import vw_prune_pkg::*;
#(
    parameter int DW = 8,
    parameter int L  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [DW-1:0]          in_data,
    input  logic                   in_last,
    output logic                   in_ready,
    output logic                   grp_valid,
    output logic [L-1:0][DW-1:0]   grp_data,
    input  logic                   grp_take
);
    localparam int CW = $clog2(L);
    localparam logic [CW-1:0] LAST_POS = CW'(L - 1);

    typedef struct packed {
        vw_mode_e              mode;
        logic [CW-1:0]         pos;
        logic [L-1:0][DW-1:0]  elems;
    } col_st_t;

    col_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        in_ready  = (st_q.mode == MODE_FILL);
        grp_valid = (st_q.mode == MODE_HOLD);
        grp_data  = st_q.elems;
        case (st_q.mode)
            MODE_FILL: begin
                if (in_valid) begin
                    st_d.elems[st_q.pos] = in_data;
                    if (st_q.pos == LAST_POS) begin
                        st_d.mode = MODE_HOLD;
                        st_d.pos  = '0;
                    end else begin
                        st_d.pos  = st_q.pos + 1'b1;
                        if (in_last) st_d.mode = MODE_PAD;
                    end
                end
            end
            MODE_PAD: begin
                st_d.elems[st_q.pos] = '0;
                if (st_q.pos == LAST_POS) begin
                    st_d.mode = MODE_HOLD;
                    st_d.pos  = '0;
                end else begin
                    st_d.pos  = st_q.pos + 1'b1;
                end
            end
            default: begin
                if (grp_take) st_d.mode = MODE_FILL;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_FILL;
            st_q.pos   <= '0;
            st_q.elems <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_GROUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && !grp_take) |=> (grp_valid && $stable(grp_data))); // R1

    AST_PAD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_PAD) |-> (!in_ready && st_q.pos != '0)); // R2
endmodule

// File: rtl/vw_topk_select.sv
module vw_topk_select #(
    parameter int DW = 8,
    parameter int L  = 16,
    parameter int K  = 4
) (
    input  logic [L-1:0][DW-1:0]            grp,
    output logic [K-1:0][DW-1:0]            kvals,
    output logic [K-1:0][$clog2(L)-1:0]     koffs,
    output logic [$clog2(L+1)-1:0]          zcount
);
    localparam int OW = $clog2(L);
    localparam int ZW = $clog2(L+1);

    logic [L-1:0][DW:0] mag;
    logic [L-1:0]       keep;

    for (genvar gi = 0; gi < L; gi++) begin : g_mag
        assign mag[gi] = grp[gi][DW-1] ? ({1'b0, ~grp[gi]} + 1'b1) : {1'b0, grp[gi]};
    end

    always_comb begin
        for (int i = 0; i < L; i++) begin
            int beaten;
            beaten = 0;
            for (int j = 0; j < L; j++) begin
                if (j != i) begin
                    if ((mag[j] > mag[i]) || ((mag[j] == mag[i]) && (j < i))) beaten++;
                end
            end
            keep[i] = (beaten < K);
        end
    end

    always_comb begin
        int slot;
        slot  = 0;
        kvals = '0;
        koffs = '0;
        for (int i = 0; i < L; i++) begin
            if (keep[i]) begin
                if (slot < K) begin
                    kvals[slot] = grp[i];
                    koffs[slot] = OW'(i);
                end
                slot++;
            end
        end
    end

    always_comb begin
        logic [ZW-1:0] zc;
        zc = '0;
        for (int i = 0; i < L; i++) begin
            if (grp[i] == '0) zc = zc + 1'b1;
        end
        zcount = zc;
    end
endmodule

// File: rtl/vw_packet_emit.sv
module vw_packet_emit #(
    parameter int DW = 8,
    parameter int L  = 16,
    parameter int K  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            grp_valid,
    output logic                            grp_take,
    input  logic [K-1:0][DW-1:0]            kvals,
    input  logic [K-1:0][$clog2(L)-1:0]     koffs,
    input  logic [$clog2(L+1)-1:0]          zcount,
    output logic                            out_valid,
    input  logic                            out_ready,
    output logic [K-1:0][DW-1:0]            out_vals,
    output logic [K-1:0][$clog2(L)-1:0]     out_offs,
    output logic [$clog2(L+1)-1:0]          out_zeros
);
    localparam int OW = $clog2(L);
    localparam int ZW = $clog2(L+1);

    typedef struct packed {
        logic                   valid;
        logic [K-1:0][DW-1:0]   vals;
        logic [K-1:0][OW-1:0]   offs;
        logic [ZW-1:0]          zeros;
    } emit_st_t;

    emit_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        grp_take = grp_valid && (!st_q.valid || out_ready);
        if (grp_take) begin
            st_d.valid = 1'b1;
            st_d.vals  = kvals;
            st_d.offs  = koffs;
            st_d.zeros = zcount;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
        out_valid = st_q.valid;
        out_vals  = st_q.vals;
        out_offs  = st_q.offs;
        out_zeros = st_q.zeros;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [K-1:0] nz_mask;
    int           nz_expect;
    always_comb begin
        for (int k = 0; k < K; k++) nz_mask[k] = (st_q.vals[k] != '0);
        nz_expect = (L - int'(st_q.zeros) < K) ? (L - int'(st_q.zeros)) : K;
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vals)
                                       && $stable(out_offs) && $stable(out_zeros))); // R7

    AST_KEPT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(nz_mask) == nz_expect)); // R3

    AST_ZERO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_zeros) <= L)); // R6

    for (genvar gk = 1; gk < K; gk++) begin : g_order
        AST_OFFS_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_offs[gk] > out_offs[gk-1])); // R5
    end
endmodule

// File: rtl/vw_sparse_pruner.sv
module vw_sparse_pruner #(
    parameter int DW = 8,
    parameter int L  = 16,
    parameter int K  = 4,
    localparam int OW = $clog2(L),
    localparam int ZW = $clog2(L+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DW-1:0]     in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [K*DW-1:0]   out_vals,
    output logic [K*OW-1:0]   out_offs,
    output logic [ZW-1:0]     out_zeros
);
    logic                  grp_valid;
    logic                  grp_take;
    logic [L-1:0][DW-1:0]  grp_data;
    logic [K-1:0][DW-1:0]  sel_vals;
    logic [K-1:0][OW-1:0]  sel_offs;
    logic [ZW-1:0]         sel_zeros;
    logic [K-1:0][DW-1:0]  emit_vals;
    logic [K-1:0][OW-1:0]  emit_offs;

    vw_group_collect #(.DW(DW), .L(L)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .grp_valid (grp_valid),
        .grp_data  (grp_data),
        .grp_take  (grp_take)
    );

    vw_topk_select #(.DW(DW), .L(L), .K(K)) u_select (
        .grp    (grp_data),
        .kvals  (sel_vals),
        .koffs  (sel_offs),
        .zcount (sel_zeros)
    );

    vw_packet_emit #(.DW(DW), .L(L), .K(K)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_valid (grp_valid),
        .grp_take  (grp_take),
        .kvals     (sel_vals),
        .koffs     (sel_offs),
        .zcount    (sel_zeros),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_vals  (emit_vals),
        .out_offs  (emit_offs),
        .out_zeros (out_zeros)
    );

    assign out_vals = emit_vals;
    assign out_offs = emit_offs;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready)); // R8
endmodule

// File: tb/sim_vw_sparse_pruner.sv
module sim_vw_sparse_pruner;
    localparam int DW = 8;
    localparam int L  = 8;
    localparam int K  = 3;
    localparam int OW = $clog2(L);
    localparam int ZW = $clog2(L+1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DW-1:0]     in_data = '0;
    logic              in_last = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [K*DW-1:0]   out_vals;
    logic [K*OW-1:0]   out_offs;
    logic [ZW-1:0]     out_zeros;

    always #10 clk = ~clk;

    vw_sparse_pruner #(.DW(DW), .L(L), .K(K)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_vals(out_vals), .out_offs(out_offs), .out_zeros(out_zeros)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    logic [K*DW-1:0] q_vals[$];
    logic [K*OW-1:0] q_offs[$];
    logic [ZW-1:0]   q_zero[$];

    int cur[L];
    int cur_n = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int magn(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Reference: repeated pick of the largest magnitude, first index wins ties.
    task automatic close_group();
        bit taken[L];
        logic [K*DW-1:0] ev;
        logic [K*OW-1:0] eo;
        int zc;
        int s;
        ev = '0; eo = '0; zc = 0; s = 0;
        for (int i = 0; i < L; i++) taken[i] = 0;
        for (int k = 0; k < K; k++) begin
            int best;
            best = -1;
            for (int i = 0; i < L; i++)
                if (!taken[i] && (best < 0 || magn(cur[i]) > magn(cur[best]))) best = i;
            taken[best] = 1;
        end
        for (int i = 0; i < L; i++) begin
            if (cur[i] == 0) zc++;
            if (taken[i]) begin
                ev[s*DW +: DW] = DW'(cur[i]);
                eo[s*OW +: OW] = OW'(i);
                s++;
            end
        end
        q_vals.push_back(ev);
        q_offs.push_back(eo);
        q_zero.push_back(ZW'(zc));
        cur_n = 0;
    endtask

    function automatic int elem(input int kind, input int idx);
        int h;
        case (kind)
            0: begin
                h = (idx * 73 + 29) % 256;
                if (h % 4 == 0) return 0;
                return (h > 127) ? h - 256 : h;
            end
            1: return 0;
            2: begin
                if (idx % 3 == 0) return 0;
                return (idx % 2 == 1) ? 5 : -5;
            end
            3: begin
                case (idx % 4)
                    0: return -128;
                    1: return 127;
                    2: return -127;
                    default: return 1;
                endcase
            end
            default: return (idx % 5 == 2) ? idx + 1 : 0;
        endcase
    endfunction

    task automatic send(input int v, input bit last);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'(v);
        in_last  = last;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        cur[cur_n] = v;
        cur_n++;
        if (cur_n == L) close_group();
        else if (last) begin
            for (int i = cur_n; i < L; i++) cur[i] = 0;
            close_group();
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send_row(input int n, input int kind);
        for (int i = 0; i < n; i++) begin
            send(elem(kind, i), i == n - 1);
            if (i % 7 == 6) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Packet monitor: sets out_ready, then compares the packet the next edge takes.
    initial begin
        forever begin
            @(negedge clk);
            out_ready = ((cyc * 7) % 11) < 7 && !(cyc > 300 && cyc < 330);
            if (rst_n && out_valid && out_ready) begin
                if (q_vals.size() == 0) begin
                    check(0, "R1 unexpected packet", 64'(out_vals), 0);
                end else begin
                    logic [K*DW-1:0] ev;
                    logic [K*OW-1:0] eo;
                    logic [ZW-1:0]   ez;
                    ev = q_vals.pop_front();
                    eo = q_offs.pop_front();
                    ez = q_zero.pop_front();
                    check(out_vals == ev, "R3/R4 kept values", 64'(out_vals), 64'(ev));
                    check(out_offs == eo, "R5 offsets", 64'(out_offs), 64'(eo));
                    check(out_zeros == ez, "R6 zero count", 64'(out_zeros), 64'(ez));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            check(0, "watchdog", 64'(cyc), 0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid, "R8 out_valid in reset", 64'(out_valid), 0);
        check(in_ready, "R8 in_ready in reset", 64'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R8 out_valid after reset", 64'(out_valid), 0);
        check(in_ready, "R8 in_ready after reset", 64'(in_ready), 1);
        // R1 R2: every row length up to 2L+1 with each pattern kind
        for (int n = 1; n <= 2 * L + 1; n++) begin
            for (int kind = 0; kind < 5; kind++) send_row(n, kind);
        end
        // R3 extremes and R4 ties/fill over longer rows
        send_row(3 * L, 3);
        send_row(3 * L + 2, 2);
        send_row(2 * L - 1, 4);
        while (q_vals.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check(!out_valid, "R1 no extra packet", 64'(out_valid), 0);
        check(q_vals.size() == 0, "R1 all packets seen", 64'(q_vals.size()), 0);
        finish_run();
    end
endmodule